// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Collector

The block gathers a set of level-sensitive interrupt request lines (64 by default) and drives one interrupt line towards the processor. Each source has its own enable, a software-forced request and a small priority level. Among the pending sources the block picks a winner and presents a vector address. That address is computed from a programmable table base plus four times the winning source number.

Software reaches the block through a plain 32-bit read/write bus with combinational read data. Every register can be reached at four alias addresses: plain write, OR-in, clear-bits and toggle. A service routine claims the current interrupt in one of two ways, chosen by a control bit: it writes the vector register, or it reads it. It ends the service by writing a one to the matching bit of the level-done register. The block keeps one in-service flag per priority level. A request at a strictly higher level can therefore nest over one being serviced, unless nesting is switched off.

Top module: `prio_irq_hub`

## Requirements
- R1: After reset, irq_out is low and these all read zero: the control word (0x020), every per-source word, the table base (0x160) and the vector register (0x000).
- R2: Word 0x040 returns irq_lines[31:0] and word 0x050 returns irq_lines[63:32], regardless of enables.
- R3: For every writable register, address bits [3:2] select the access: 0 writes the data, 1 ORs it in, 2 clears the bits that are one in the data, 3 toggles them. Reads at any alias return the register. In the control word only bits 16, 18 and 19 are stored; all other bits read zero.
- R4: Source n is configured in the byte at bit (n%4)*8 of word 0x060 + (n/4)*0x10. In that byte, bits [1:0] are the level, bit 2 is the enable and bit 3 is the software request. Bits [7:4] always read zero.
- R5: A source is pending when its enable is set and either its request line or its software bit is high. A disabled source never raises irq_out.
- R6: Among pending sources, the one with the highest level wins. On equal levels, the lowest source number wins.
- R7: The vector register (0x000) reads {base[31:2],2'b00} + 4*idx, and the status word (0x030) reads idx in bits [5:0], with zeros above. Here idx is the winning source while irq_out is high, and otherwise the last source shown. The table base stores bits [31:2] of the data written; bits [1:0] read zero.
- R8: irq_out is high only when control bit 16 is set, a source is pending, and no level at or above the winner's level is in service.
- R9: With control bit 18 clear, a write to the vector register while irq_out is high marks the winner's level in service. A read of the vector register does not.
- R10: With control bit 18 set, a read of the vector register while irq_out is high marks the winner's level in service and returns that winner's vector. A write of the vector register does not.
- R11: Writing word 0x010 with bit L set ends the in-service state of level L.
- R12: With control bit 19 set, irq_out stays low while any level is in service.
- R13: Writing a one to bit k of word 0x1D0 clears the software bit of source k, and writing it to word 0x1E0 clears that of source 32+k. Other sources' software bits are untouched.
- R14: Word 0x1F0 is a plain 32-bit storage register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_lines | input | NUM_SRC | Level-sensitive request lines |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| irq_out | output | 1 | Interrupt request to the processor |

## Verification
A claim by vector read and a change of the winning source can land in the same cycle. The bench provokes this in read-claim mode: while a level-1 source is in service, it raises the line of an enabled level-2 source on the same clock edge that it issues the vector read. The read must return the new source's vector. The level that goes in service must be that source's level, which shows as irq_out dropping and then returning only once level 2 is acknowledged while level 1 is still in service.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;

   typedef enum logic [1:0] {
      ACC_PLAIN = 2'd0,
      ACC_OR    = 2'd1,
      ACC_ANDN  = 2'd2,
      ACC_XOR   = 2'd3
   } acc_mode_e;

   localparam int BUS_W = 32;

   // register groups: byte address bits [ADDR_W-1:4]
   localparam logic [7:0] G_VEC   = 8'h00;
   localparam logic [7:0] G_DONE  = 8'h01;
   localparam logic [7:0] G_CTL   = 8'h02;
   localparam logic [7:0] G_STAT  = 8'h03;
   localparam logic [7:0] G_LINE0 = 8'h04;
   localparam logic [7:0] G_LINE1 = 8'h05;
   localparam logic [7:0] G_SRC0  = 8'h06;
   localparam logic [7:0] G_BASE  = 8'h16;
   localparam logic [7:0] G_CLR0  = 8'h1D;
   localparam logic [7:0] G_CLR1  = 8'h1E;
   localparam logic [7:0] G_SPARE = 8'h1F;

   localparam int CTL_GEN_BIT  = 16;
   localparam int CTL_RCLM_BIT = 18;
   localparam int CTL_NONE_BIT = 19;

   function automatic logic [BUS_W-1:0] merge_wr(input logic [BUS_W-1:0] cur,
                                                 input logic [BUS_W-1:0] wd,
                                                 input acc_mode_e m);
      case (m)
         ACC_PLAIN: return wd;
         ACC_OR:    return cur | wd;
         ACC_ANDN:  return cur & ~wd;
         default:   return cur ^ wd;
      endcase
   endfunction

endpackage

// File: rtl/irq_pick.sv
module irq_pick #(
   parameter int NUM_SRC = 64,
   parameter int PRIO_W  = 2,
   localparam int NUM_LVL = 1 << PRIO_W,
   localparam int IDX_W   = $clog2(NUM_SRC)
) (
   input  logic [NUM_SRC-1:0]        pend,
   input  logic [NUM_SRC*PRIO_W-1:0] lvl_flat,
   output logic                      win_valid,
   output logic [IDX_W-1:0]          win_idx,
   output logic [PRIO_W-1:0]         win_lvl
);

   function automatic logic [IDX_W-1:0] lowest_set(input logic [NUM_SRC-1:0] v);
      logic [IDX_W-1:0] r;
      r = '0;
      for (int i = NUM_SRC - 1; i >= 0; i--)
         if (v[i]) r = IDX_W'(i);
      return r;
   endfunction

   logic [NUM_LVL-1:0] lvl_any;
   logic [IDX_W-1:0]   lvl_idx [NUM_LVL];

   // one lowest-index finder per level, all in parallel
   for (genvar l = 0; l < NUM_LVL; l++) begin : g_lvl
      logic [NUM_SRC-1:0] hit;
      for (genvar n = 0; n < NUM_SRC; n++) begin : g_src
         assign hit[n] = pend[n] && (lvl_flat[n*PRIO_W +: PRIO_W] == PRIO_W'(l));
      end
      assign lvl_any[l] = |hit;
      assign lvl_idx[l] = lowest_set(hit);
   end

   always_comb begin
      win_valid = 1'b0;
      win_idx   = '0;
      win_lvl   = '0;
      for (int l = 0; l < NUM_LVL; l++) begin
         if (lvl_any[l]) begin
            win_valid = 1'b1;
            win_idx   = lvl_idx[l];
            win_lvl   = PRIO_W'(l);
         end
      end
   end

endmodule

// File: rtl/irq_level_track.sv
module irq_level_track #(
   parameter int PRIO_W = 2,
   localparam int NUM_LVL = 1 << PRIO_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               gen_en,
   input  logic               nest_off,
   input  logic               win_valid,
   input  logic [PRIO_W-1:0]  win_lvl,
   input  logic               entry,
   input  logic               ack_wr,
   input  logic [NUM_LVL-1:0] ack_bits,
   output logic [NUM_LVL-1:0] in_svc,
   output logic               irq_ok
);

   logic [NUM_LVL-1:0] ack_mask, entry_mask;
   logic               none_at_or_above;

   assign ack_mask   = ack_wr ? ack_bits : '0;
   assign entry_mask = entry ? (NUM_LVL'(1) << win_lvl) : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) in_svc <= '0;
      else        in_svc <= (in_svc & ~ack_mask) | entry_mask;
   end

   assign none_at_or_above = ((in_svc >> win_lvl) == '0);
   assign irq_ok = gen_en && win_valid &&
                   (nest_off ? (in_svc == '0) : none_at_or_above);

endmodule

// File: rtl/prio_irq_hub.sv
module prio_irq_hub
   import prio_irq_pkg::*;
#(
   parameter int NUM_SRC = 64,
   parameter int PRIO_W  = 2,
   parameter int ADDR_W  = 12
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] irq_lines,
   input  logic [ADDR_W-1:0]  bus_addr,
   input  logic               bus_wr,
   input  logic               bus_rd,
   input  logic [31:0]        bus_wdata,
   output logic [31:0]        bus_rdata,
   output logic               irq_out
);

   localparam int NUM_LVL   = 1 << PRIO_W;
   localparam int IDX_W     = $clog2(NUM_SRC);
   localparam int NUM_WORDS = NUM_SRC / 4;
   localparam int WSEL_W    = $clog2(NUM_WORDS);
   localparam int GW        = ADDR_W - 4;

   if (NUM_SRC % 32 != 0 || NUM_SRC < 32 || NUM_SRC > 64) begin : g_bad_src
      $error("NUM_SRC must be 32 or 64");
   end
   if (PRIO_W < 1 || PRIO_W > 2) begin : g_bad_prio
      $error("PRIO_W must be 1 or 2");
   end
   if (ADDR_W < 9) begin : g_bad_addr
      $error("ADDR_W must be at least 9");
   end

   // ---------------- decode ----------------
   logic [GW-1:0]     grp;
   acc_mode_e         mode;
   logic              src_hit;
   logic [WSEL_W-1:0] sel_w;

   assign grp     = bus_addr[ADDR_W-1:4];
   assign mode    = acc_mode_e'(bus_addr[3:2]);
   assign src_hit = (grp >= GW'(G_SRC0)) && (grp < GW'(G_SRC0) + GW'(NUM_WORDS));
   assign sel_w   = WSEL_W'(grp - GW'(G_SRC0));

   // ---------------- state ----------------
   logic              gen_en, rd_claim, nest_off;
   logic [29:0]       tbase;
   logic [31:0]       spare;
   logic [IDX_W-1:0]  held_idx, shown_idx;

   logic [PRIO_W-1:0] s_lvl [NUM_SRC];
   logic              s_en  [NUM_SRC];
   logic              s_sw  [NUM_SRC];

   logic [NUM_SRC-1:0]        pend;
   logic [NUM_SRC*PRIO_W-1:0] lvl_flat;
   logic [31:0]               word_img [NUM_WORDS];
   logic [31:0]               wr_word, cfg_img, cfg_new, base_new;

   logic               win_valid, irq_ok, entry, ack_wr;
   logic [IDX_W-1:0]   win_idx;
   logic [PRIO_W-1:0]  win_lvl;
   logic [NUM_LVL-1:0] in_svc;

   assign cfg_img  = 32'({nest_off, rd_claim, 1'b0, gen_en}) << CTL_GEN_BIT;
   assign cfg_new  = merge_wr(cfg_img, bus_wdata, mode);
   assign base_new = merge_wr({tbase, 2'b00}, bus_wdata, mode);
   assign wr_word  = merge_wr(word_img[sel_w], bus_wdata, mode);

   // ---------------- per-source storage ----------------
   for (genvar n = 0; n < NUM_SRC; n++) begin : g_src
      localparam logic [7:0] MY_CLR = (n < 32) ? G_CLR0 : G_CLR1;
      localparam int         SH     = (n % 4) * 8;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            s_lvl[n] <= '0;
            s_en[n]  <= 1'b0;
            s_sw[n]  <= 1'b0;
         end else if (bus_wr && src_hit && sel_w == WSEL_W'(n / 4)) begin
            s_lvl[n] <= wr_word[SH +: PRIO_W];
            s_en[n]  <= wr_word[SH + 2];
            s_sw[n]  <= wr_word[SH + 3];
         end else if (bus_wr && grp == GW'(MY_CLR) && bus_wdata[n % 32]) begin
            s_sw[n]  <= 1'b0;
         end
      end

      assign pend[n] = s_en[n] && (irq_lines[n] || s_sw[n]);
      assign lvl_flat[n*PRIO_W +: PRIO_W] = s_lvl[n];
      assign word_img[n / 4][SH +: 8] = {4'b0000, s_sw[n], s_en[n], 2'(s_lvl[n])};
   end

   // ---------------- global registers ----------------
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gen_en   <= 1'b0;
         rd_claim <= 1'b0;
         nest_off <= 1'b0;
         tbase    <= '0;
         spare    <= '0;
         held_idx <= '0;
      end else begin
         held_idx <= shown_idx;
         if (bus_wr && grp == GW'(G_CTL)) begin
            gen_en   <= cfg_new[CTL_GEN_BIT];
            rd_claim <= cfg_new[CTL_RCLM_BIT];
            nest_off <= cfg_new[CTL_NONE_BIT];
         end
         if (bus_wr && grp == GW'(G_BASE))  tbase <= base_new[31:2];
         if (bus_wr && grp == GW'(G_SPARE)) spare <= merge_wr(spare, bus_wdata, mode);
      end
   end

   // ---------------- selection and level tracking ----------------
   irq_pick #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W)) u_pick (
      .pend      (pend),
      .lvl_flat  (lvl_flat),
      .win_valid (win_valid),
      .win_idx   (win_idx),
      .win_lvl   (win_lvl)
   );

   assign entry  = irq_ok && grp == GW'(G_VEC) && (rd_claim ? bus_rd : bus_wr);
   assign ack_wr = bus_wr && grp == GW'(G_DONE);

   irq_level_track #(.PRIO_W(PRIO_W)) u_track (
      .clk       (clk),
      .rst_n     (rst_n),
      .gen_en    (gen_en),
      .nest_off  (nest_off),
      .win_valid (win_valid),
      .win_lvl   (win_lvl),
      .entry     (entry),
      .ack_wr    (ack_wr),
      .ack_bits  (bus_wdata[NUM_LVL-1:0]),
      .in_svc    (in_svc),
      .irq_ok    (irq_ok)
   );

   assign shown_idx = irq_ok ? win_idx : held_idx;
   assign irq_out   = irq_ok;

   // ---------------- read mux ----------------
   logic [63:0] raw64;
   assign raw64 = 64'(irq_lines);

   always_comb begin
      if (grp == GW'(G_VEC))        bus_rdata = {tbase + 30'(shown_idx), 2'b00};
      else if (grp == GW'(G_CTL))   bus_rdata = cfg_img;
      else if (grp == GW'(G_STAT))  bus_rdata = 32'(shown_idx);
      else if (grp == GW'(G_LINE0)) bus_rdata = raw64[31:0];
      else if (grp == GW'(G_LINE1)) bus_rdata = raw64[63:32];
      else if (src_hit)             bus_rdata = word_img[sel_w];
      else if (grp == GW'(G_BASE))  bus_rdata = {tbase, 2'b00};
      else if (grp == GW'(G_SPARE)) bus_rdata = spare;
      else                          bus_rdata = '0;
   end

   logic unused_bits;
   assign unused_bits = ^{bus_addr[1:0], cfg_new, base_new[1:0], wr_word, bus_wdata};

endmodule

// File: rtl/prio_irq_hub_chk.sv
module prio_irq_hub_chk #(
   parameter int NUM_LVL = 4,
   parameter int ADDR_W  = 12
) (
   input logic               clk,
   input logic               rst_n,
   input logic               irq_out,
   input logic               gen_en,
   input logic               nest_off,
   input logic               win_valid,
   input logic [NUM_LVL-1:0] in_svc,
   input logic               entry,
   input logic               ack_wr,
   input logic [NUM_LVL-1:0] ack_bits,
   input logic               bus_rd,
   input logic [ADDR_W-1:0]  bus_addr,
   input logic [31:0]        bus_rdata
);

   // R8
   irq_needs_gen_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !gen_en |-> !irq_out);

   // R5
   irq_has_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_out |-> win_valid);

   // R12
   no_nest_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (nest_off && in_svc != '0) |-> !irq_out);

   // R11
   done_clears_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_wr && !entry) |=> ((in_svc & $past(ack_bits)) == '0));

   // R9
   claim_marks_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
      entry |=> (in_svc != '0));

   // R7
   vec_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && bus_addr[ADDR_W-1:4] == '0) |-> (bus_rdata[1:0] == 2'b00));

endmodule

bind prio_irq_hub prio_irq_hub_chk #(.NUM_LVL(NUM_LVL), .ADDR_W(ADDR_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .irq_out   (irq_out),
   .gen_en    (gen_en),
   .nest_off  (nest_off),
   .win_valid (win_valid),
   .in_svc    (in_svc),
   .entry     (entry),
   .ack_wr    (ack_wr),
   .ack_bits  (bus_wdata[NUM_LVL-1:0]),
   .bus_rd    (bus_rd),
   .bus_addr  (bus_addr),
   .bus_rdata (bus_rdata)
);

// File: tb/sim_prio_irq_hub.sv
`timescale 1ns/1ps
module sim_prio_irq_hub;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [63:0] lines = '0;
   logic [11:0] addr = '0;
   logic        wr = 1'b0, rd = 1'b0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic        irq;

   int n_chk = 0;
   int n_bad = 0;

   always #5 clk = ~clk;

   prio_irq_hub u0 (
      .clk       (clk),
      .rst_n     (rst_n),
      .irq_lines (lines),
      .bus_addr  (addr),
      .bus_wr    (wr),
      .bus_rd    (rd),
      .bus_wdata (wdata),
      .bus_rdata (rdata),
      .irq_out   (irq)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
      @(negedge clk);
      addr = a; wdata = d; wr = 1'b1;
      @(posedge clk); #1;
      wr = 1'b0;
   endtask

   task automatic bus_read(input logic [11:0] a, output logic [31:0] d);
      @(negedge clk);
      addr = a; rd = 1'b1;
      #1 d = rdata;
      @(posedge clk); #1;
      rd = 1'b0;
   endtask

   task automatic read_check(input string req, input logic [11:0] a, input logic [31:0] exp);
      logic [31:0] d;
      bus_read(a, d);
      check(req, d, exp);
   endtask

   task automatic irq_check(input string req, input logic exp);
      @(negedge clk);
      check(req, 32'(irq), 32'(exp));
   endtask

   // R4: clear the source byte, then OR in the new value
   task automatic set_src(input int n, input logic [3:0] v);
      logic [11:0] w;
      int sh;
      w  = 12'(12'h060 + (n / 4) * 16);
      sh = (n % 4) * 8;
      bus_write(w + 12'h8, 32'hF << sh);
      bus_write(w + 12'h4, 32'(v) << sh);
   endtask

   task automatic t_reset;
      irq_check("R1 irq low", 1'b0);
      read_check("R1 ctl", 12'h020, 32'h0);
      read_check("R1 src word", 12'h060, 32'h0);
      read_check("R1 base", 12'h160, 32'h0);
      read_check("R1 vector", 12'h000, 32'h0);
   endtask

   task automatic t_raw;
      @(negedge clk) lines = 64'h8000_0001_1234_5678;
      read_check("R2 low half", 12'h040, 32'h1234_5678);
      read_check("R2 high half", 12'h050, 32'h8000_0001);
      @(negedge clk) lines = '0;
   endtask

   task automatic t_alias;
      bus_write(12'h1F0, 32'hA5A5_0F0F);
      read_check("R14 scratch", 12'h1F0, 32'hA5A5_0F0F);
      bus_write(12'h1F4, 32'h0000_F000);
      read_check("R3 or alias", 12'h1F0, 32'hA5A5_FF0F);
      bus_write(12'h1F8, 32'hA500_0000);
      read_check("R3 clear alias", 12'h1F0, 32'h00A5_FF0F);
      bus_write(12'h1FC, 32'hFFFF_0000);
      read_check("R3 toggle alias", 12'h1FC, 32'hFF5A_FF0F);
      bus_write(12'h024, 32'h0001_0000);
      read_check("R3 ctl set", 12'h020, 32'h0001_0000);
      bus_write(12'h02C, 32'h000C_0000);
      read_check("R3 ctl toggle", 12'h020, 32'h000D_0000);
      bus_write(12'h028, 32'h000C_0000);
      read_check("R3 ctl clear", 12'h020, 32'h0001_0000);
      bus_write(12'h020, 32'hFFFF_FFFF);
      read_check("R3 ctl stored bits", 12'h020, 32'h000D_0000);
      bus_write(12'h020, 32'h0001_0000);
   endtask

   task automatic t_pack;
      set_src(13, 4'hF);
      read_check("R4 source 13 byte", 12'h090, 32'h0000_0F00);
      bus_write(12'h094, 32'h0000_00F0);
      read_check("R4 upper nibble zero", 12'h090, 32'h0000_0F00);
      set_src(13, 4'h0);
      read_check("R4 cleared", 12'h090, 32'h0);
      bus_write(12'h160, 32'h1000_0003);
      read_check("R7 base low bits", 12'h160, 32'h1000_0000);
   endtask

   task automatic t_pending;
      set_src(5, 4'b0101);
      irq_check("R5 enabled no request", 1'b0);
      @(negedge clk) lines[5] = 1'b1;
      irq_check("R5 line pending", 1'b1);
      read_check("R7 status", 12'h030, 32'd5);
      read_check("R7 vector", 12'h000, 32'h1000_0014);
      irq_check("R9 read does not claim", 1'b1);
      set_src(5, 4'b0001);
      irq_check("R5 disabled ignored", 1'b0);
      @(negedge clk) lines[5] = 1'b0;
      set_src(5, 4'b0000);
      set_src(40, 4'b1110);
      irq_check("R5 software request", 1'b1);
      read_check("R7 vector 40", 12'h000, 32'h1000_00A0);
      bus_write(12'h1D0, 32'h0000_0100);
      irq_check("R13 other half untouched", 1'b1);
      bus_write(12'h1E0, 32'h0000_0100);
      irq_check("R13 software cleared", 1'b0);
      read_check("R13 byte after clear", 12'h100, 32'h0000_0006);
      set_src(40, 4'b0000);
   endtask

   task automatic t_arb;
      set_src(7, 4'b0110);
      set_src(3, 4'b0110);
      @(negedge clk) begin lines[7] = 1'b1; lines[3] = 1'b1; end
      read_check("R6 tie lowest index", 12'h030, 32'd3);
      set_src(9, 4'b0111);
      @(negedge clk) lines[9] = 1'b1;
      read_check("R6 higher level", 12'h030, 32'd9);
      set_src(2, 4'b0101);
      @(negedge clk) lines[2] = 1'b1;
      read_check("R6 lower level loses", 12'h030, 32'd9);
   endtask

   task automatic t_claim_write;
      bus_write(12'h000, 32'h0);
      irq_check("R9 write claims", 1'b0);
      read_check("R7 status held", 12'h030, 32'd9);
      bus_write(12'h010, 32'h8);
      irq_check("R11 done level 3", 1'b1);
      set_src(2, 0); set_src(3, 0); set_src(7, 0); set_src(9, 0);
      @(negedge clk) lines = '0;
      irq_check("R5 all idle", 1'b0);
   endtask

   task automatic t_nest;
      set_src(4, 4'b0101);
      @(negedge clk) lines[4] = 1'b1;
      bus_write(12'h000, 32'h0);
      irq_check("R9 level 1 claimed", 1'b0);
      set_src(20, 4'b0111);
      @(negedge clk) lines[20] = 1'b1;
      irq_check("R8 higher level nests", 1'b1);
      read_check("R7 nested status", 12'h030, 32'd20);
      bus_write(12'h024, 32'h0008_0000);
      irq_check("R12 nesting off", 1'b0);
      bus_write(12'h028, 32'h0008_0000);
      irq_check("R12 nesting back on", 1'b1);
      set_src(20, 4'b0000);
      @(negedge clk) lines[20] = 1'b0;
      irq_check("R8 equal level blocked", 1'b0);
      bus_write(12'h010, 32'h2);
      irq_check("R11 done level 1", 1'b1);
   endtask

   task automatic t_claim_read;
      bus_write(12'h024, 32'h0004_0000);
      bus_write(12'h000, 32'h0);
      irq_check("R10 write does not claim", 1'b1);
      read_check("R10 claim vector", 12'h000, 32'h1000_0010);
      irq_check("R10 read claims", 1'b0);
      read_check("R7 status after claim", 12'h030, 32'd4);
   endtask

   task automatic t_collide;
      logic [31:0] d;
      set_src(30, 4'b0110);
      irq_check("R8 level 2 idle", 1'b0);
      @(negedge clk);
      lines[30] = 1'b1; addr = 12'h000; rd = 1'b1;
      #1 d = rdata;
      @(posedge clk); #1 rd = 1'b0;
      check("R10 same-cycle vector", d, 32'h1000_0078);
      irq_check("R10 level 2 claimed", 1'b0);
      read_check("R7 status collide", 12'h030, 32'd30);
      bus_write(12'h010, 32'h4);
      irq_check("R11 level 2 done", 1'b1);
      read_check("R6 source 30 again", 12'h030, 32'd30);
      bus_write(12'h028, 32'h0001_0000);
      irq_check("R8 global off", 1'b0);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;
      t_reset();
      t_raw();
      t_alias();
      t_pack();
      t_pending();
      t_arb();
      t_claim_write();
      t_nest();
      t_claim_read();
      t_collide();
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

endmodule